// File: doc/BRIEF.md
# Byte-Mailbox Indirect Register Bridge

This bridge lets a narrow management port reach a 32-bit register space with 16-bit addresses. The port moves one byte per cycle. The host first writes a target address into byte registers, and for a store it also writes a 32-bit data word. It then reads a launch byte, which starts the access on the internal bus. After that it keeps reading a status byte until the code shows that the access has finished. Loads and stores each have their own address bytes, launch byte and status code set. Read data is captured into four holding bytes, and the host reads it back one byte at a time.

The byte port has a first-byte flag. A byte with the flag set uses the offset presented with it. Each byte that follows without the flag goes to the next offset, so a multi-byte field can be transferred in one burst. The internal bus uses a request that is held until ready. An error flag qualifies ready, and a watchdog ends any access that sees no ready within a set number of cycles.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, the load status byte (0xFD) and the store status byte (0xFF) both read 0xFF, the holding bytes 0xF4–0xF7 read 0x00, and `ib_req` is low.
- R2: A store drives `ib_we`=1, `ib_addr` = {byte 0xF2, byte 0xF3} and `ib_wdata` = {0xF8, 0xF9, 0xFA, 0xFB} (0xF8 is the most significant byte). `ib_req`, `ib_we`, `ib_addr` and `ib_wdata` hold steady until the cycle in which `ib_ready` is high.
- R3: A load drives `ib_we`=0 and `ib_addr` = {byte 0xF0, byte 0xF1}.
- R4: A byte presented with `bp_first`=1 uses `bp_offset`. Each later byte with `bp_first`=0 uses the previous byte's offset plus one. This holds for both reads and writes.
- R5: Reading 0xFC returns the current load status code and launches a load. The load status reads 1 (pending) in the next cycle. If the bus is idle, `ib_req` rises one cycle after that.
- R6: A load that ends with `ib_ready`=1 and `ib_err`=0 sets the load status to 0 and copies the returned word into 0xF4–0xF7, with 0xF4 as the most significant byte.
- R7: A load that ends with `ib_err`=1 sets the load status to 2 and leaves 0xF4–0xF7 unchanged.
- R8: Reading 0xFE returns the current store status code and launches a store. The store status is 5 while pending, 4 on success, and 6 when `ib_err` comes back with ready.
- R9: Reading a status byte (0xFD, 0xFF) starts no access. Writing the holding, status or launch bytes (0xF4–0xF7, 0xFC–0xFF) changes nothing and starts no access.
- R10: A launch of the same kind that arrives while that kind is pending is ignored. Only one bus request is made, and the status stays pending.
- R11: If `ib_ready` does not arrive within TIMEOUT (default 256) cycles of request, the request drops after exactly TIMEOUT cycles and the status becomes failed (2 for a load, 6 for a store).
- R12: A launch of the other kind that arrives while an access is active stays pending. Its request rises two cycles after the completing cycle: there is exactly one cycle with `ib_req` low between the two accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_valid | input | 1 | Byte transfer strobe, one byte per cycle |
| bp_first | input | 1 | Byte starts a burst and uses bp_offset |
| bp_wr | input | 1 | 1 = byte write, 0 = byte read |
| bp_offset | input | 8 | Byte offset for the first byte of a burst |
| bp_wdata | input | 8 | Write byte |
| bp_rdata | output | 8 | Read byte for the current offset (combinational) |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus store (1) or load (0) |
| ib_addr | output | 16 | Internal bus address |
| ib_wdata | output | 32 | Internal bus store data |
| ib_rdata | input | 32 | Internal bus load data, valid with ib_ready |
| ib_ready | input | 1 | Internal bus completion |
| ib_err | input | 1 | Error response, qualified by ib_ready |

## Verification
A launch read at edge E0 turns the status pending at E0. The request rises at E1, and the status and holding bytes change at the edge where `ib_ready` is sampled high. The bench therefore samples `ib_req` and the peeked status at the negative edges between those edges: pending with no request after E0, then a request after E1. It samples the gap between two queued accesses at the first and second negative edges after the completing cycle. The timeout check counts request-high cycles at negative edges and expects exactly TIMEOUT of them. Byte reads are combinational, so each returned launch byte is compared with the code that was current before that edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int BYTE_W  = 8;
    localparam int REG_AW  = 16;
    localparam int REG_DW  = 32;
    localparam int A_BYTES = REG_AW / BYTE_W;
    localparam int D_BYTES = REG_DW / BYTE_W;

    // Offset map: the upper nibble selects the mailbox, bits [3:2] the region
    localparam logic [3:0] MBOX_PAGE  = 4'hF;
    localparam logic [1:0] RGN_ADDR   = 2'b00;
    localparam logic [1:0] RGN_HOLD   = 2'b01;
    localparam logic [1:0] RGN_WDATA  = 2'b10;
    localparam logic [1:0] RGN_STAT   = 2'b11;

    localparam logic [7:0] OFS_LD_GO  = 8'hFC;
    localparam logic [7:0] OFS_ST_GO  = 8'hFE;

    // Status code bases: success = base, pending = base+1, failed = base+2
    localparam logic [7:0] LD_BASE    = 8'h00;
    localparam logic [7:0] ST_BASE    = 8'h04;
    localparam logic [7:0] CODE_RESET = 8'hFF;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PEND = 2'd1,
        PH_OK   = 2'd2,
        PH_FAIL = 2'd3
    } phase_t;

    typedef enum logic {
        ACC_LD = 1'b0,
        ACC_ST = 1'b1
    } acc_kind_t;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } bus_cmd_t;

    typedef struct packed {
        logic       wr_en;
        logic       rd_en;
        logic [7:0] off;
    } byte_acc_t;

    function automatic logic [7:0] stat_code(input acc_kind_t k, input phase_t p);
        logic [7:0] base;
        base = (k == ACC_LD) ? LD_BASE : ST_BASE;
        case (p)
            PH_IDLE: stat_code = CODE_RESET;
            PH_PEND: stat_code = base + 8'd1;
            PH_OK:   stat_code = base;
            default: stat_code = base + 8'd2;
        endcase
    endfunction

    function automatic logic in_page(input logic [7:0] off, input logic [1:0] rgn);
        in_page = (off[7:4] == MBOX_PAGE) && (off[3:2] == rgn);
    endfunction

endpackage

// File: rtl/mbox_port.sv
module mbox_port
    import mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bp_valid,
    input  logic       bp_first,
    input  logic       bp_wr,
    input  logic [7:0] bp_offset,
    output byte_acc_t  acc,
    output logic       go_ld,
    output logic       go_st
);

    logic [7:0] ptr_q;
    logic [7:0] eff_off;

    assign eff_off = bp_first ? bp_offset : ptr_q;

    // Next-offset pointer: advances by one per byte, wraps at the top
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (bp_valid) begin
            ptr_q <= eff_off + 8'd1;
        end
    end

    always_comb begin
        acc.wr_en = bp_valid &  bp_wr;
        acc.rd_en = bp_valid & ~bp_wr;
        acc.off   = eff_off;
    end

    assign go_ld = acc.rd_en && (eff_off == OFS_LD_GO);
    assign go_st = acc.rd_en && (eff_off == OFS_ST_GO);

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  byte_acc_t         acc,
    input  logic [7:0]        bp_wdata,
    input  logic [7:0]        ld_code,
    input  logic [7:0]        st_code,
    input  logic              cap_en,
    input  logic [REG_DW-1:0] cap_word,
    output logic [7:0]        bp_rdata,
    output logic [REG_AW-1:0] ld_addr,
    output logic [REG_AW-1:0] st_addr,
    output logic [REG_DW-1:0] st_data,
    output logic [REG_DW-1:0] hold_word
);

    localparam int AREG_N = 2 * A_BYTES;

    logic [7:0] addr_q  [AREG_N];
    logic [7:0] wdata_q [D_BYTES];
    logic [7:0] hold_q  [D_BYTES];

    logic       hit_addr;
    logic       hit_wdata;
    logic [1:0] sub;

    assign hit_addr  = acc.wr_en && in_page(acc.off, RGN_ADDR);
    assign hit_wdata = acc.wr_en && in_page(acc.off, RGN_WDATA);
    assign sub       = acc.off[1:0];

    // Address bytes: load high/low, then store high/low
    for (genvar i = 0; i < AREG_N; i++) begin : g_addr
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[i] <= '0;
            end else if (hit_addr && (sub == 2'(i))) begin
                addr_q[i] <= bp_wdata;
            end
        end
    end

    // Store data and load holding bytes, index 0 = most significant
    for (genvar i = 0; i < D_BYTES; i++) begin : g_data
        always_ff @(posedge clk) begin
            if (rst) begin
                wdata_q[i] <= '0;
            end else if (hit_wdata && (sub == 2'(i))) begin
                wdata_q[i] <= bp_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[i] <= '0;
            end else if (cap_en) begin
                hold_q[i] <= cap_word[REG_DW-1-8*i -: 8];
            end
        end

        assign st_data[REG_DW-1-8*i -: 8]   = wdata_q[i];
        assign hold_word[REG_DW-1-8*i -: 8] = hold_q[i];
    end

    for (genvar i = 0; i < A_BYTES; i++) begin : g_abus
        assign ld_addr[REG_AW-1-8*i -: 8] = addr_q[i];
        assign st_addr[REG_AW-1-8*i -: 8] = addr_q[A_BYTES+i];
    end

    always_comb begin
        bp_rdata = '0;
        if (acc.off[7:4] == MBOX_PAGE) begin
            case (acc.off[3:2])
                RGN_ADDR:  bp_rdata = addr_q[sub];
                RGN_HOLD:  bp_rdata = hold_q[sub];
                RGN_WDATA: bp_rdata = wdata_q[sub];
                default:   bp_rdata = sub[1] ? st_code : ld_code;
            endcase
        end
    end

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_ld,
    input  logic              go_st,
    input  logic [REG_AW-1:0] ld_addr,
    input  logic [REG_AW-1:0] st_addr,
    input  logic [REG_DW-1:0] st_data,
    input  logic              ib_ready,
    input  logic              ib_err,
    output logic              ib_req,
    output bus_cmd_t          cmd,
    output phase_t            ld_phase,
    output phase_t            st_phase,
    output logic              cap_en
);

    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    phase_t           ld_ph_q, st_ph_q;
    logic             act_q;
    bus_cmd_t         cmd_q;
    logic [CNT_W-1:0] wait_q;

    logic expired, finish, failed, start_ld, start_st;

    assign expired  = act_q && !ib_ready && (wait_q == CNT_LAST);
    assign finish   = act_q && (ib_ready || expired);
    assign failed   = expired || (act_q && ib_ready && ib_err);
    assign start_ld = !act_q && (ld_ph_q == PH_PEND);
    assign start_st = !act_q && !start_ld && (st_ph_q == PH_PEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_ph_q <= PH_IDLE;
            st_ph_q <= PH_IDLE;
            act_q   <= 1'b0;
            cmd_q   <= '0;
            wait_q  <= '0;
        end else begin
            if (go_ld && (ld_ph_q != PH_PEND)) begin
                ld_ph_q <= PH_PEND;
            end
            if (go_st && (st_ph_q != PH_PEND)) begin
                st_ph_q <= PH_PEND;
            end

            if (finish) begin
                act_q <= 1'b0;
                if (cmd_q.we) begin
                    st_ph_q <= failed ? PH_FAIL : PH_OK;
                end else begin
                    ld_ph_q <= failed ? PH_FAIL : PH_OK;
                end
            end else if (start_ld || start_st) begin
                act_q    <= 1'b1;
                wait_q   <= '0;
                cmd_q.we <= start_st;
                cmd_q.addr <= start_st ? st_addr : ld_addr;
                cmd_q.data <= start_st ? st_data : '0;
            end else if (act_q) begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    assign ib_req   = act_q;
    assign cmd      = cmd_q;
    assign ld_phase = ld_ph_q;
    assign st_phase = st_ph_q;
    assign cap_en   = act_q && ib_ready && !ib_err && !cmd_q.we;

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bp_valid,
    input  logic        bp_first,
    input  logic        bp_wr,
    input  logic [7:0]  bp_offset,
    input  logic [7:0]  bp_wdata,
    output logic [7:0]  bp_rdata,
    output logic        ib_req,
    output logic        ib_we,
    output logic [15:0] ib_addr,
    output logic [31:0] ib_wdata,
    input  logic [31:0] ib_rdata,
    input  logic        ib_ready,
    input  logic        ib_err
);

    byte_acc_t         acc;
    logic              go_ld, go_st, cap_en;
    logic [REG_AW-1:0] ld_addr, st_addr;
    logic [REG_DW-1:0] st_data, hold_word;
    bus_cmd_t          cmd;
    phase_t            ld_phase, st_phase;
    logic [7:0]        ld_code, st_code;

    assign ld_code = stat_code(ACC_LD, ld_phase);
    assign st_code = stat_code(ACC_ST, st_phase);

    mbox_port u_port (
        .clk       (clk),
        .rst       (rst),
        .bp_valid  (bp_valid),
        .bp_first  (bp_first),
        .bp_wr     (bp_wr),
        .bp_offset (bp_offset),
        .acc       (acc),
        .go_ld     (go_ld),
        .go_st     (go_st)
    );

    mbox_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .bp_wdata  (bp_wdata),
        .ld_code   (ld_code),
        .st_code   (st_code),
        .cap_en    (cap_en),
        .cap_word  (ib_rdata),
        .bp_rdata  (bp_rdata),
        .ld_addr   (ld_addr),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .hold_word (hold_word)
    );

    mbox_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go_ld    (go_ld),
        .go_st    (go_st),
        .ld_addr  (ld_addr),
        .st_addr  (st_addr),
        .st_data  (st_data),
        .ib_ready (ib_ready),
        .ib_err   (ib_err),
        .ib_req   (ib_req),
        .cmd      (cmd),
        .ld_phase (ld_phase),
        .st_phase (st_phase),
        .cap_en   (cap_en)
    );

    assign ib_we    = cmd.we;
    assign ib_addr  = cmd.addr;
    assign ib_wdata = cmd.data;

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
    parameter int TIMEOUT = 256
) (
    input logic        clk,
    input logic        rst,
    input logic        ib_req,
    input logic        ib_ready,
    input logic        ib_err,
    input logic        ib_we,
    input logic [15:0] ib_addr,
    input logic [31:0] ib_wdata,
    input logic [7:0]  ld_code,
    input logic [7:0]  st_code,
    input logic [31:0] hold_word
);

    localparam int CW = $clog2(TIMEOUT + 1);
    logic [CW-1:0] waited;

    always_ff @(posedge clk) begin
        if (rst || !ib_req || ib_ready) begin
            waited <= '0;
        end else begin
            waited <= waited + 1'b1;
        end
    end

    assert_cmd_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ready) |=> (!ib_req ||
            ($stable(ib_we) && $stable(ib_addr) && $stable(ib_wdata))));

    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ready && (waited < CW'(TIMEOUT - 1))) |=> ib_req);

    assert_timeout_R11: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ready && (waited == CW'(TIMEOUT - 1))) |=>
            (!ib_req && ($past(ib_we) ? (st_code == 8'h06) : (ld_code == 8'h02))));

    assert_ld_ok_R6: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ready && !ib_we && !ib_err) |=> (ld_code == 8'h00));

    assert_ld_fail_R7: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ready && !ib_we && ib_err) |=>
            ((ld_code == 8'h02) && $stable(hold_word)));

    assert_st_done_R8: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ready && ib_we) |=>
            (st_code == ($past(ib_err) ? 8'h06 : 8'h04)));

    assert_codes_R5: assert property (@(posedge clk) disable iff (rst)
        ((ld_code == 8'hFF) || (ld_code <= 8'h02)) &&
        ((st_code == 8'hFF) || ((st_code >= 8'h04) && (st_code <= 8'h06))));

    assert_req_pending_R10: assert property (@(posedge clk) disable iff (rst)
        ib_req |-> (ib_we ? (st_code == 8'h05) : (ld_code == 8'h01)));

endmodule

bind mbox_bridge mbox_chk #(.TIMEOUT(TIMEOUT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ib_req    (ib_req),
    .ib_ready  (ib_ready),
    .ib_err    (ib_err),
    .ib_we     (ib_we),
    .ib_addr   (ib_addr),
    .ib_wdata  (ib_wdata),
    .ld_code   (ld_code),
    .st_code   (st_code),
    .hold_word (hold_word)
);

// File: tb/mbox_bridge_tb.sv
module mbox_bridge_tb_top;

    localparam int TMO = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bp_valid = 1'b0, bp_first = 1'b0, bp_wr = 1'b0;
    logic [7:0]  bp_offset = '0, bp_wdata = '0;
    logic [7:0]  bp_rdata;
    logic        ib_req, ib_we;
    logic [15:0] ib_addr;
    logic [31:0] ib_wdata;
    logic [31:0] ib_rdata = '0;
    logic        ib_ready = 1'b0, ib_err = 1'b0;

    int n_tot = 0, n_bad = 0;

    always #5 clk = ~clk;

    mbox_bridge #(.TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst(rst),
        .bp_valid(bp_valid), .bp_first(bp_first), .bp_wr(bp_wr),
        .bp_offset(bp_offset), .bp_wdata(bp_wdata), .bp_rdata(bp_rdata),
        .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_rdata(ib_rdata), .ib_ready(ib_ready), .ib_err(ib_err)
    );

    // Internal bus responder model
    int          sl_lat = 0, sl_cnt = 0, n_req = 0, req_cyc = 0;
    logic        sl_err = 1'b0, sl_hang = 1'b0;
    logic [31:0] sl_rdata = '0;
    logic        log_we = 1'b0, prev_we = 1'b0;
    logic [15:0] log_addr = '0;
    logic [31:0] log_data = '0;

    always @(negedge clk) begin
        if (ib_req) begin
            if (sl_cnt == 0) n_req++;
            req_cyc++;
            if (!sl_hang && sl_cnt == sl_lat) begin
                ib_ready = 1'b1;
                ib_err   = sl_err;
                ib_rdata = sl_rdata;
                prev_we  = log_we;
                log_we   = ib_we;
                log_addr = ib_addr;
                log_data = ib_wdata;
            end else begin
                ib_ready = 1'b0;
                ib_err   = 1'b0;
            end
            sl_cnt++;
        end else begin
            sl_cnt   = 0;
            ib_ready = 1'b0;
            ib_err   = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bp_cyc(input logic f, input logic w, input logic [7:0] off,
                          input logic [7:0] d, output logic [7:0] r);
        @(negedge clk);
        bp_valid = 1'b1; bp_first = f; bp_wr = w; bp_offset = off; bp_wdata = d;
        #1 r = bp_rdata;
        @(posedge clk);
        #1 bp_valid = 1'b0; bp_first = 1'b0; bp_wr = 1'b0;
    endtask

    task automatic load_word(input logic [7:0] off, input logic [31:0] w);
        logic [7:0] r;
        for (int i = 0; i < 4; i++) bp_cyc(i == 0, 1'b1, off, w[31-8*i -: 8], r);
    endtask

    task automatic load_half(input logic [7:0] off, input logic [15:0] a);
        logic [7:0] r;
        bp_cyc(1'b1, 1'b1, off, a[15:8], r);
        bp_cyc(1'b0, 1'b1, 8'h00, a[7:0], r);
    endtask

    task automatic read_word(input logic [7:0] off, output logic [31:0] w);
        logic [7:0] r;
        for (int i = 0; i < 4; i++) begin
            bp_cyc(i == 0, 1'b0, off, 8'h00, r);
            w[31-8*i -: 8] = r;
        end
    endtask

    task automatic poll(input logic [7:0] off, input logic [7:0] pend, output logic [7:0] r);
        int k = 0;
        bp_cyc(1'b1, 1'b0, off, 8'h00, r);
        while (r == pend && k < 2000) begin
            bp_cyc(1'b1, 1'b0, off, 8'h00, r);
            k++;
        end
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] data;
        logic [7:0]  lat;
        logic        err;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1234, 32'hDEADBEEF, 8'd0, 1'b0},
        '{1'b1, 16'hA55A, 32'h01234567, 8'd3, 1'b0},
        '{1'b0, 16'h00FF, 32'h5555AAAA, 8'd2, 1'b1},
        '{1'b1, 16'hFFFE, 32'h89ABCDEF, 8'd0, 1'b1},
        '{1'b0, 16'h8001, 32'hC0FFEE11, 8'd7, 1'b0},
        '{1'b1, 16'h0042, 32'hFEDCBA98, 8'd1, 1'b0}
    };

    logic [7:0]  exp_ld = 8'hFF, exp_st = 8'hFF;
    logic [31:0] exp_hold = '0;

    initial begin
        #2_000_000;
        n_tot++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [31:0] w;
        int          n0;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        bp_cyc(1'b1, 1'b0, 8'hFD, 8'h00, r); check("R1 ld status", r, 8'hFF);
        bp_cyc(1'b1, 1'b0, 8'hFF, 8'h00, r); check("R1 st status", r, 8'hFF);
        read_word(8'hF4, w);                 check("R1 hold", w, 32'h0);
        check("R1 req", ib_req, 1'b0);

        // R4: one burst over all four address bytes, read back as a burst
        load_word(8'hF0, 32'h12345678);
        read_word(8'hF0, w);
        check("R4 burst addr", w, 32'h12345678);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            sl_lat = int'(VECS[v].lat); sl_err = VECS[v].err;
            sl_rdata = VECS[v].data; sl_hang = 1'b0;
            n0 = n_req;
            if (VECS[v].we) begin
                load_half(8'hF2, VECS[v].addr);
                load_word(8'hF8, VECS[v].data);
                bp_cyc(1'b1, 1'b0, 8'hFE, 8'h00, r);
                check("R8 launch returns prior code", r, exp_st);
                poll(8'hFF, 8'h05, r);
                exp_st = VECS[v].err ? 8'h06 : 8'h04;
                check("R8 st final", r, exp_st);
                check("R2 we", log_we, 1'b1);
                check("R2 addr", log_addr, VECS[v].addr);
                check("R2 data", log_data, VECS[v].data);
            end else begin
                load_half(8'hF0, VECS[v].addr);
                bp_cyc(1'b1, 1'b0, 8'hFC, 8'h00, r);
                check("R5 launch returns prior code", r, exp_ld);
                poll(8'hFD, 8'h01, r);
                exp_ld = VECS[v].err ? 8'h02 : 8'h00;
                if (!VECS[v].err) exp_hold = VECS[v].data;
                check(VECS[v].err ? "R7 ld fail" : "R6 ld ok", r, exp_ld);
                read_word(8'hF4, w);
                check(VECS[v].err ? "R7 hold kept" : "R6 hold", w, exp_hold);
                check("R3 we", log_we, 1'b0);
                check("R3 addr", log_addr, VECS[v].addr);
            end
            check("R9 polling one request", n_req, n0 + 1);
        end

        // R9: writes to read-only and launch bytes do nothing
        n0 = n_req;
        bp_cyc(1'b1, 1'b1, 8'hF4, 8'hAA, r);
        bp_cyc(1'b1, 1'b1, 8'hFD, 8'h55, r);
        bp_cyc(1'b1, 1'b1, 8'hFC, 8'h00, r);
        bp_cyc(1'b1, 1'b1, 8'hFE, 8'h00, r);
        repeat (4) @(negedge clk);
        check("R9 no request", n_req, n0);
        read_word(8'hF4, w);                 check("R9 hold", w, exp_hold);
        bp_cyc(1'b1, 1'b0, 8'hFD, 8'h00, r); check("R9 ld code", r, exp_ld);
        bp_cyc(1'b1, 1'b0, 8'hFF, 8'h00, r); check("R9 st code", r, exp_st);

        // R5 timing, R10 retrigger, R12 queued other kind
        n0 = n_req;
        sl_lat = 20; sl_err = 1'b0; sl_rdata = 32'h600DF00D;
        load_half(8'hF0, 16'h00AB);
        load_half(8'hF2, 16'h0CD0);
        load_word(8'hF8, 32'h11223344);
        bp_cyc(1'b1, 1'b0, 8'hFC, 8'h00, r);
        check("R5 launch code", r, exp_ld);
        @(negedge clk);
        bp_offset = 8'hFD;
        #1 check("R5 no req yet", ib_req, 1'b0);
        check("R5 pending", bp_rdata, 8'h01);
        @(negedge clk);
        #1 check("R5 req rises", ib_req, 1'b1);
        check("R3 addr live", ib_addr, 16'h00AB);
        bp_cyc(1'b1, 1'b0, 8'hFC, 8'h00, r);
        check("R10 retrigger sees pending", r, 8'h01);
        bp_cyc(1'b1, 1'b0, 8'hFE, 8'h00, r);
        check("R12 st launch code", r, exp_st);
        begin
            int k = 0;
            do begin @(negedge clk); #2; k++; end while (!ib_ready && k < 100);
        end
        @(negedge clk); #2 check("R12 gap", ib_req, 1'b0);
        @(negedge clk); #2 check("R12 store starts", {ib_req, ib_we}, 2'b11);
        poll(8'hFF, 8'h05, r);
        exp_st = 8'h04; check("R12 st done", r, exp_st);
        check("R12 order", {prev_we, log_we}, 2'b01);
        check("R10 one load", n_req, n0 + 2);
        bp_cyc(1'b1, 1'b0, 8'hFD, 8'h00, r);
        exp_ld = 8'h00; exp_hold = 32'h600DF00D;
        check("R10 ld ok", r, exp_ld);

        // R11: timeout on a hung load
        sl_hang = 1'b1; req_cyc = 0;
        bp_cyc(1'b1, 1'b0, 8'hFC, 8'h00, r);
        poll(8'hFD, 8'h01, r);
        check("R11 ld fail", r, 8'h02);
        check("R11 req cycles", req_cyc, TMO);
        check("R11 released", ib_req, 1'b0);
        read_word(8'hF4, w);
        check("R7 hold after timeout", w, exp_hold);
        sl_hang = 1'b0;

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule